// File: doc/BRIEF.md
# Dual-Bank GPIO Controller

This block provides general-purpose pins behind a small byte-wide register bus. The pins are split into two banks. The core bank is cleared by the core reset. The resume bank has its own reset, so its settings survive a core-only reset. Each bank has three register blocks of four bytes each:

- **enable**: turns a pin on.
- **direction**: a 1 makes the pin an input, a 0 makes it an output.
- **level**: drives an output pin and reports the state of an input pin.

Software addresses a pin by picking the bank, then the register block, then byte pin/8 and bit pin%8. The pin counts of the two banks are parameters, so one design covers splits such as 10/4, 21/9 and 2/6.

Each pin drives a pad output value and a pad output enable, and it receives a pad input value. Pad inputs go through a two-flop synchronizer before software can see them. A level bit cannot be preset while its pin is an input. Software must switch the pin to output first and then write the level.

Top module: `gpio_dualbank`

## Requirements
- R1: Address decode. Bit 5 selects the bank (0 core, 1 resume). Bits 3:2 select the block: 0 enable, 1 direction, 2 level. Bits 1:0 select the byte, which holds pins 8*byte to 8*byte+7 with pin p at bit p%8. In this map, core pin 9 is enable 0x01 bit 1, direction 0x05 bit 1 and level 0x09 bit 1.
- R2: After reset, a bank has these values. The enable bits of core pins 0..CORE_EN_RST-1 (default 7) and resume pins 0..RESUME_EN_RST-1 (default 3) are 1, and all other enable bits are 0. Every direction bit is 1 (input), every stored level is 0 and every pad output enable is 0.
- R3: A pad output enable is 1 exactly when the pin's enable bit is 1 and its direction bit is 0.
- R4: A write to a level bit whose direction bit is 1 leaves the stored level unchanged. A level written before the pin became an output is therefore not presented once it does.
- R5: Reading the level bit of an enabled output pin returns the last value written to it. The pad output carries that value while the output enable is 1, and carries 0 otherwise.
- R6: Reading the level bit of an enabled input pin returns the pad input after two flops. A pad change made just before clock edge k is returned by a read sampled at edge k+2 or later. A read sampled at edge k or k+1 still returns the old value.
- R7: A pin whose enable bit is 0 reads 0 from its level bit and keeps its pad output enable at 0, whatever its direction bit holds.
- R8: The following read 0 and ignore writes: register bits for pins at or beyond the bank's pin count, addresses with bit 4 set, and the unused block (bits 3:2 = 3).
- R9: Asserting the core reset leaves all resume-bank registers and pads unchanged. Asserting the resume reset returns only the resume bank to its R2 values.
- R10: A read strobe sampled at a clock edge loads the addressed byte into `bus_rdata` at that edge. `bus_rdata` holds this value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Synchronous active-low reset of the core bank and read port |
| resume_rst_n | input | 1 | Synchronous active-low reset of the resume bank |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| core_pad_in | input | CORE_PINS | Core-bank pad input values |
| core_pad_out | output | CORE_PINS | Core-bank pad output values |
| core_pad_oe | output | CORE_PINS | Core-bank pad output enables |
| resume_pad_in | input | RESUME_PINS | Resume-bank pad input values |
| resume_pad_out | output | RESUME_PINS | Resume-bank pad output values |
| resume_pad_oe | output | RESUME_PINS | Resume-bank pad output enables |

## Verification
The level register is exercised in four stages:
- It is written while every pin is an input and then read back after the switch to output. This separates real write gating from a preset that leaks through.
- It is written with a mixed pattern (0xA5) while one pin is still disabled. This shows that the enable masks the readback but not the stored value.
- A byte is split into output and input halves. The pad inputs are changed between reads in that byte, which separates the stored-level path from the synchronized-pad path.
- A pad change is read with three back-to-back reads. This pins the synchronizer depth to exactly two flops.

Separate sequences check the following:
- Out-of-range bits and unused addresses.
- A pin in the second byte, which tests the byte and bit mapping.
- A core-only reset, then a resume-only reset, which separates the two reset domains.

// File: rtl/gpio_db_pkg.sv
// Package: shared types and address constants for the dual-bank GPIO controller.
// Assumes a 6-bit byte address space with at most 32 pins per bank.
package gpio_db_pkg;
    localparam int ADDR_W   = 6;
    localparam int MAX_PINS = 32;
    localparam int BANK_BIT = 5;
    localparam int HOLE_BIT = 4;

    typedef enum logic [1:0] {
        RS_ENABLE = 2'd0,
        RS_DIR    = 2'd1,
        RS_LEVEL  = 2'd2,
        RS_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_db_sync.sv
// Module: two-flop synchronizer for a vector of pad inputs.
// Assumes each bit is independent (no multi-bit coherency needed).
module gpio_db_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift pad values through two flops, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/gpio_db_bank.sv
// Module: one bank of GPIO pins, holding the enable, direction and level registers.
// Assumes the write strobe is already qualified for this bank. Byte index and
// register select come straight from the address. Direction 1 means input.
// Level writes take effect only on output pins.
module gpio_db_bank import gpio_db_pkg::*; #(
    parameter int PINS   = 10,
    parameter int EN_RST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        rsel,
    input  logic [1:0]      byte_idx,
    input  logic [7:0]      wdata,
    output logic [7:0]      rd_byte,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    logic [PINS-1:0] en_vec;
    logic [PINS-1:0] dir_vec;
    logic [PINS-1:0] lvl_vis;
    logic [PINS-1:0] sync_in;

    gpio_db_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (sync_in)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        localparam int BYTE_N = p / 8;
        localparam int BIT_N  = p % 8;
        logic en_b, dir_b, lvl_b, hit;

        assign hit = wr_en && (byte_idx == 2'(BYTE_N));

        // Per-pin register slice: reset defaults, then byte-lane writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_b  <= (p < EN_RST);
                dir_b <= 1'b1;
                lvl_b <= 1'b0;
            end else if (hit) begin
                case (rsel)
                    RS_ENABLE: en_b  <= wdata[BIT_N];
                    RS_DIR:    dir_b <= wdata[BIT_N];
                    RS_LEVEL:  if (!dir_b) lvl_b <= wdata[BIT_N];
                    default:   ;
                endcase
            end
        end

        assign en_vec[p]  = en_b;
        assign dir_vec[p] = dir_b;
        assign pad_oe[p]  = en_b & ~dir_b;
        assign pad_out[p] = lvl_b & en_b & ~dir_b;
        assign lvl_vis[p] = en_b & (dir_b ? sync_in[p] : lvl_b);
    end

    // Pad each register view to the full block width and pick the addressed byte.
    always_comb begin
        logic [MAX_PINS-1:0] view;
        view = '0;
        case (rsel)
            RS_ENABLE: view[PINS-1:0] = en_vec;
            RS_DIR:    view[PINS-1:0] = dir_vec;
            RS_LEVEL:  view[PINS-1:0] = lvl_vis;
            default:   view = '0;
        endcase
        rd_byte = view[8*byte_idx +: 8];
    end
endmodule

// File: rtl/gpio_dualbank.sv
// Module: top of the dual-bank GPIO controller. It decodes the byte bus,
// routes writes to the core or resume bank, and registers read data.
// Assumes a single clock. The core bank and the read register use
// core_rst_n; the resume bank uses only resume_rst_n.
module gpio_dualbank import gpio_db_pkg::*; #(
    parameter int CORE_PINS     = 10,
    parameter int RESUME_PINS   = 4,
    parameter int CORE_EN_RST   = 7,
    parameter int RESUME_EN_RST = 3
) (
    input  logic                   clk,
    input  logic                   core_rst_n,
    input  logic                   resume_rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [CORE_PINS-1:0]   core_pad_in,
    output logic [CORE_PINS-1:0]   core_pad_out,
    output logic [CORE_PINS-1:0]   core_pad_oe,
    input  logic [RESUME_PINS-1:0] resume_pad_in,
    output logic [RESUME_PINS-1:0] resume_pad_out,
    output logic [RESUME_PINS-1:0] resume_pad_oe
);
    logic     in_range;
    logic     core_wr, res_wr;
    reg_sel_e rsel;
    logic [7:0] core_rd_byte, res_rd_byte, sel_byte;
    logic [7:0] rdata_q;

    // Address decode: bank select, hole detection and register block.
    assign in_range = ~bus_addr[HOLE_BIT];
    assign rsel     = reg_sel_e'(bus_addr[3:2]);
    assign core_wr  = bus_wr & in_range & ~bus_addr[BANK_BIT];
    assign res_wr   = bus_wr & in_range &  bus_addr[BANK_BIT];

    gpio_db_bank #(.PINS(CORE_PINS), .EN_RST(CORE_EN_RST)) u_core (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .wr_en    (core_wr),
        .rsel     (rsel),
        .byte_idx (bus_addr[1:0]),
        .wdata    (bus_wdata),
        .rd_byte  (core_rd_byte),
        .pad_in   (core_pad_in),
        .pad_out  (core_pad_out),
        .pad_oe   (core_pad_oe)
    );

    gpio_db_bank #(.PINS(RESUME_PINS), .EN_RST(RESUME_EN_RST)) u_resume (
        .clk      (clk),
        .rst_n    (resume_rst_n),
        .wr_en    (res_wr),
        .rsel     (rsel),
        .byte_idx (bus_addr[1:0]),
        .wdata    (bus_wdata),
        .rd_byte  (res_rd_byte),
        .pad_in   (resume_pad_in),
        .pad_out  (resume_pad_out),
        .pad_oe   (resume_pad_oe)
    );

    // Read mux: choose the bank, and return zero for the hole.
    always_comb begin
        if (!in_range)                sel_byte = 8'h00;
        else if (bus_addr[BANK_BIT])  sel_byte = res_rd_byte;
        else                          sel_byte = core_rd_byte;
    end

    // Read data register: load on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!core_rst_n)  rdata_q <= 8'h00;
        else if (bus_rd)  rdata_q <= sel_byte;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_dualbank_chk.sv
// Module: assertion checker for gpio_dualbank, attached with bind.
// Assumes both banks have at least one pin. Core pin 0 is the probe for
// the per-pin properties.
module gpio_dualbank_chk #(
    parameter int CORE_PINS   = 10,
    parameter int RESUME_PINS = 4
) (
    input logic                   clk,
    input logic                   core_rst_n,
    input logic                   resume_rst_n,
    input logic [5:0]             bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [CORE_PINS-1:0]   core_pad_out,
    input logic [CORE_PINS-1:0]   core_pad_oe,
    input logic [RESUME_PINS-1:0] resume_pad_out,
    input logic [RESUME_PINS-1:0] resume_pad_oe
);
    // R2: reset leaves every output enable of the bank at 0.
    p_core_reset_oe_r2: assert property (@(posedge clk)
        !core_rst_n |=> core_pad_oe == '0);
    p_resume_reset_oe_r2: assert property (@(posedge clk)
        !resume_rst_n |=> resume_pad_oe == '0);

    // R7: clearing core pin 0's enable bit drops its output enable.
    p_disable_drops_oe_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
        (bus_wr && bus_addr == 6'h00 && !bus_wdata[0]) |=> !core_pad_oe[0]);

    // R3: making core pin 0 an input drops its output enable.
    p_input_drops_oe_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
        (bus_wr && bus_addr == 6'h04 && bus_wdata[0]) |=> !core_pad_oe[0]);

    // R5: a level write to a driving pin appears on the pad one edge later.
    p_level_to_pad_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (bus_wr && bus_addr == 6'h08 && core_pad_oe[0])
        |=> core_pad_out[0] == $past(bus_wdata[0]));

    // R8: the unused register block reads back as zero.
    p_hole_reads_zero_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
        (bus_rd && bus_addr[3:2] == 2'b11) |=> bus_rdata == 8'h00);

    // R9: a core reset without bus writes leaves the resume pads untouched.
    p_resume_survives_r9: assert property (@(posedge clk) disable iff (!resume_rst_n)
        (!core_rst_n && !bus_wr) |=> ($stable(resume_pad_oe) && $stable(resume_pad_out)));

    // R10: read data holds while no read strobe is sampled.
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!core_rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_dualbank gpio_dualbank_chk #(
    .CORE_PINS   (CORE_PINS),
    .RESUME_PINS (RESUME_PINS)
) u_chk (
    .clk            (clk),
    .core_rst_n     (core_rst_n),
    .resume_rst_n   (resume_rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .core_pad_out   (core_pad_out),
    .core_pad_oe    (core_pad_oe),
    .resume_pad_out (resume_pad_out),
    .resume_pad_oe  (resume_pad_oe)
);

// File: tb/gpio_dualbank_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for gpio_dualbank. Read tasks queue the expected bytes,
// and a monitor compares bus_rdata once each read has landed.
module gpio_dualbank_bench;
    localparam int CP = 10;
    localparam int RP = 4;

    logic          clk = 1'b0;
    logic          core_rst_n = 1'b0;
    logic          resume_rst_n = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [CP-1:0] core_pad_in = '0;
    logic [CP-1:0] core_pad_out, core_pad_oe;
    logic [RP-1:0] resume_pad_in = '0;
    logic [RP-1:0] resume_pad_out, resume_pad_oe;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    gpio_dualbank #(.CORE_PINS(CP), .RESUME_PINS(RP)) u_gpio_dualbank (
        .clk            (clk),
        .core_rst_n     (core_rst_n),
        .resume_rst_n   (resume_rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .core_pad_in    (core_pad_in),
        .core_pad_out   (core_pad_out),
        .core_pad_oe    (core_pad_oe),
        .resume_pad_in  (resume_pad_in),
        .resume_pad_out (resume_pad_out),
        .resume_pad_oe  (resume_pad_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver tasks: called at a falling edge, and return at the next falling edge.
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: when a read strobe is sampled, compare bus_rdata at the following falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd === 1'b1) begin
                @(negedge clk);
                if (sbq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R10 unexpected read actual=%0h expected=none", bus_rdata);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk({24'h0, bus_rdata}, {24'h0, it.exp}, it.tag);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        core_rst_n = 1'b1; resume_rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk(core_pad_oe, 0, "R2 core oe after reset");
        chk(resume_pad_oe, 0, "R2 resume oe after reset");
        rd(6'h00, 8'h7F, "R2 core enable byte0");
        rd(6'h01, 8'h00, "R2 core enable byte1");
        rd(6'h04, 8'hFF, "R2 core direction byte0");
        rd(6'h05, 8'h03, "R8 core direction byte1 beyond pins");
        rd(6'h20, 8'h07, "R2 resume enable");
        rd(6'h24, 8'h0F, "R2 resume direction");

        // R4: level write while input is ignored
        wr(6'h08, 8'hFF);
        rd(6'h08, 8'h00, "R6 inputs read pads low");
        wr(6'h04, 8'h00);
        rd(6'h08, 8'h00, "R4 level not preset");
        chk(core_pad_oe, 10'h07F, "R3 oe enabled outputs only");
        chk(core_pad_out, 10'h000, "R4 pads low after switch");

        // R5 and R7: output readback with pin 7 disabled
        wr(6'h08, 8'hA5);
        rd(6'h08, 8'h25, "R7 disabled pin reads 0");
        chk(core_pad_out, 10'h025, "R5 pad out pattern");
        wr(6'h00, 8'hFF);
        rd(6'h08, 8'hA5, "R5 level readback");
        chk(core_pad_oe, 10'h0FF, "R3 oe after enable");

        // R6: mixed byte, with the upper nibble as inputs
        wr(6'h04, 8'hF0);
        core_pad_in = 10'h0A0;
        idle(3);
        rd(6'h08, 8'hA5, "R6 pads A0 with outputs 5");
        core_pad_in = 10'h050;
        idle(3);
        rd(6'h08, 8'h55, "R6 pads 50 with outputs 5");
        chk(core_pad_oe, 10'h00F, "R3 oe lower nibble");
        core_pad_in = 10'h000;
        rd(6'h08, 8'h55, "R6 read at edge k old");
        rd(6'h08, 8'h55, "R6 read at edge k+1 old");
        rd(6'h08, 8'h05, "R6 read at edge k+2 new");
        idle(3);
        chk(bus_rdata, 8'h05, "R10 rdata held");

        // R8: out-of-range bits and holes
        wr(6'h05, 8'hFF);
        rd(6'h05, 8'h03, "R8 direction byte1 masked");
        wr(6'h0C, 8'hFF);
        rd(6'h0C, 8'h00, "R8 unused block");
        wr(6'h10, 8'hFF);
        rd(6'h10, 8'h00, "R8 hole address");
        rd(6'h23, 8'h00, "R8 resume byte3 empty");
        rd(6'h00, 8'hFF, "R8 hole write left enable");

        // R9: resume bank against core reset
        wr(6'h24, 8'h00);
        wr(6'h28, 8'h0F);
        chk(resume_pad_oe, 4'h7, "R7 resume pin3 disabled");
        chk(resume_pad_out, 4'h7, "R5 resume pad out");
        wr(6'h20, 8'h0F);
        chk(resume_pad_oe, 4'hF, "R3 resume all outputs");
        core_rst_n = 1'b0;
        idle(3);
        chk(core_pad_oe, 0, "R9 core cleared by core reset");
        chk(resume_pad_oe, 4'hF, "R9 resume oe kept");
        chk(resume_pad_out, 4'hF, "R9 resume out kept");
        core_rst_n = 1'b1;
        @(negedge clk);
        rd(6'h28, 8'h0F, "R9 resume level kept");
        rd(6'h00, 8'h7F, "R9 core enable reset");
        resume_rst_n = 1'b0;
        idle(2);
        resume_rst_n = 1'b1;
        @(negedge clk);
        chk(resume_pad_oe, 0, "R9 resume reset clears oe");
        rd(6'h20, 8'h07, "R9 resume enable default");
        rd(6'h05, 8'h03, "R9 core untouched by resume reset");

        // R1: byte and bit mapping for pin 9
        wr(6'h01, 8'h02);
        wr(6'h05, 8'h00);
        wr(6'h09, 8'h02);
        chk(core_pad_oe[9:8], 2'b10, "R1 pin9 oe only");
        chk(core_pad_out[9:8], 2'b10, "R1 pin9 drives high");
        rd(6'h09, 8'h02, "R1 pin9 level readback");

        idle(2);
        if (sbq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R10 pending reads actual=%0d expected=0", sbq.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule